// File: doc/BRIEF.md
# Synchronous Dual-Port Byte-Lane RAM

This block is a shared word memory with two ports, left and right, that can read and write the same array in the same clock cycle. Each word is 18 bits and is split into two 9-bit lanes. Each port has its own chip-select pair, read/write strobe, lane selects, output-enable and read-latency mode pin. Address, data and control are captured on the rising clock edge. A write stores only the lanes that are selected. A read returns data only on the lanes that are selected.

Read results are presented as a data word plus a two-bit lane-drive vector. This stands in for tri-state pins: an undriven lane reads as zero. The read path is not a stream. It cannot be stalled, and a read issued on a cycle always produces its result a fixed number of edges later. Each port's mode pin picks flow-through latency, with data out after the sampling edge, or pipelined latency, which adds one edge. The mode pin is static. The output-enable gates the lane-drive vector straight away, without a clock. Both ports run from one clock, so that collisions on the same address have a defined cycle-by-cycle result. Depth is set by `ADDR_W`. A value of 15 gives the full 32K-word array, and the default is smaller.

Top module: `dual_lane_sram`

## Requirements
- R1: Lane mask encoding: `lane_n[0]` low selects the lower lane (bits 8:0) and `lane_n[1]` low selects the upper lane (bits 17:9). A write changes only the selected lanes. A read drives only the selected lanes. `lane_on[i]` reports lane i driven, and an undriven lane reads as zero on `rdata`.
- R2: A port is selected only when `cs_n` is 0 and `cs` is 1. In any other case the port stores nothing and, from the next edge on, drives neither lane.
- R3: With the port selected, `rd_wr_n`=1 is a read and `rd_wr_n`=0 is a write of the selected lanes. With both lanes deselected, no lane is written or driven.
- R4: In flow-through mode (`pipe`=0), read data for an address sampled on edge k is presented after edge k.
- R5: In pipelined mode (`pipe`=1), read data for an address sampled on edge k is presented after edge k+1.
- R6: A lane stops being driven because of deselection or its lane select going high only after the next rising edge. Until that edge it keeps the previous read result.
- R7: In pipelined mode, a read result is driven only if the port was also selected on the edge before the read. After a deselect, the first pipelined read result is suppressed.
- R8: `oe_n`=1 turns both lanes off at once, with no clock edge. It has no effect on reads and writes inside the block.
- R9: If one port writes an address on the same edge that the other port reads it, the reader gets the old contents. A read on any later edge returns the new contents.
- R10: If both ports write the same address and lane on the same edge, the left port's data is stored.
- R11: Reset (`rst_n`=0, asynchronous) clears the read and lane-drive pipeline and the select history, so no lane is driven. It leaves the array contents unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both ports |
| rst_n | input | 1 | Asynchronous active-low reset of output state |
| l_cs_n | input | 1 | Left active-low chip select |
| l_cs | input | 1 | Left active-high chip select |
| l_rd_wr_n | input | 1 | Left read (1) / write (0) |
| l_lane_n | input | 2 | Left active-low lane selects, bit 1 upper |
| l_addr | input | ADDR_W | Left word address |
| l_wdata | input | 18 | Left write data |
| l_oe_n | input | 1 | Left asynchronous active-low output enable |
| l_pipe | input | 1 | Left latency mode, 1 = pipelined |
| l_rdata | output | 18 | Left read data, zero on undriven lanes |
| l_lane_on | output | 2 | Left per-lane drive indication |
| r_cs_n | input | 1 | Right active-low chip select |
| r_cs | input | 1 | Right active-high chip select |
| r_rd_wr_n | input | 1 | Right read (1) / write (0) |
| r_lane_n | input | 2 | Right active-low lane selects, bit 1 upper |
| r_addr | input | ADDR_W | Right word address |
| r_wdata | input | 18 | Right write data |
| r_oe_n | input | 1 | Right asynchronous active-low output enable |
| r_pipe | input | 1 | Right latency mode, 1 = pipelined |
| r_rdata | output | 18 | Right read data, zero on undriven lanes |
| r_lane_on | output | 2 | Right per-lane drive indication |

## Verification
A corrupt select-history bit shows up only in pipelined mode. There it drives a lane one read too early after a deselect, or suppresses it one read too late, within two edges of the deselect. A wrong lane-enable register shows on `lane_on` after the very next edge in flow-through mode, or one edge later when pipelined. Write-priority or lane-mask faults stay hidden in the array until a later read of that address. The bench therefore reads every written address back, and reads the collision addresses back straight after the collision.

// File: rtl/dls_pkg.sv
package dls_pkg;
  localparam int LANE_W = 9;
  localparam int LANES  = 2;
  localparam int WORD_W = LANE_W * LANES;

  function automatic logic port_selected(input logic cs_n, input logic cs);
    return !cs_n && cs;
  endfunction
endpackage

// File: rtl/dls_lane_bank.sv
module dls_lane_bank #(
  parameter int ADDR_W = 10,
  parameter int W      = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              l_we,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic [W-1:0]      l_wd,
  input  logic              r_we,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic [W-1:0]      r_wd,
  output logic [W-1:0]      l_rd,
  output logic [W-1:0]      r_rd
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [W-1:0] mem [DEPTH];

  // right first, left last: on a same-address clash the left value lands
  always_ff @(posedge clk) begin
    if (r_we) mem[r_addr] <= r_wd;
    if (l_we) mem[l_addr] <= l_wd;
  end

  // synchronous read returns pre-write contents on a same-edge write
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      l_rd <= '0;
      r_rd <= '0;
    end else begin
      l_rd <= mem[l_addr];
      r_rd <= mem[r_addr];
    end
  end
endmodule

// File: rtl/dls_port_ctrl.sv
module dls_port_ctrl
  import dls_pkg::*;
#(
  parameter int LN = LANES,
  parameter int LW = LANE_W,
  localparam int WW = LN * LW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          cs,
  input  logic          rd_wr_n,
  input  logic [LN-1:0] lane_n,
  input  logic          oe_n,
  input  logic          pipe,
  input  logic [WW-1:0] bank_word,
  output logic [LN-1:0] wr_lanes,
  output logic [WW-1:0] rdata,
  output logic [LN-1:0] lane_on
);
  logic          sel;
  logic [LN-1:0] want;
  logic [LN-1:0] en_flow, en_pipe;
  logic          sel_h1, sel_h2;
  logic [WW-1:0] word_pipe;
  logic [LN-1:0] en_pick;
  logic [WW-1:0] word_pick;

  assign sel      = port_selected(cs_n, cs);
  assign want     = ~lane_n;
  assign wr_lanes = {LN{sel && !rd_wr_n}} & want;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_flow   <= '0;
      en_pipe   <= '0;
      sel_h1    <= 1'b0;
      sel_h2    <= 1'b0;
      word_pipe <= '0;
    end else begin
      en_flow   <= {LN{sel && rd_wr_n}} & want;
      sel_h1    <= sel;
      sel_h2    <= sel_h1;
      en_pipe   <= en_flow & {LN{sel_h2}};
      word_pipe <= bank_word;
    end
  end

  assign en_pick   = pipe ? en_pipe : en_flow;
  assign word_pick = pipe ? word_pipe : bank_word;
  assign lane_on   = en_pick & {LN{!oe_n}};

  for (genvar g = 0; g < LN; g++) begin : g_lane_out
    assign rdata[g*LW +: LW] = lane_on[g] ? word_pick[g*LW +: LW] : '0;
  end
endmodule

// File: rtl/dual_lane_sram.sv
module dual_lane_sram
  import dls_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              l_cs_n,
  input  logic              l_cs,
  input  logic              l_rd_wr_n,
  input  logic [1:0]        l_lane_n,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic [17:0]       l_wdata,
  input  logic              l_oe_n,
  input  logic              l_pipe,
  output logic [17:0]       l_rdata,
  output logic [1:0]        l_lane_on,
  input  logic              r_cs_n,
  input  logic              r_cs,
  input  logic              r_rd_wr_n,
  input  logic [1:0]        r_lane_n,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic [17:0]       r_wdata,
  input  logic              r_oe_n,
  input  logic              r_pipe,
  output logic [17:0]       r_rdata,
  output logic [1:0]        r_lane_on
);
  logic [LANES-1:0]  l_wr, r_wr;
  logic [WORD_W-1:0] l_word, r_word;

  for (genvar g = 0; g < LANES; g++) begin : g_bank
    dls_lane_bank #(.ADDR_W(ADDR_W), .W(LANE_W)) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .l_we   (l_wr[g]),
      .l_addr (l_addr),
      .l_wd   (l_wdata[g*LANE_W +: LANE_W]),
      .r_we   (r_wr[g]),
      .r_addr (r_addr),
      .r_wd   (r_wdata[g*LANE_W +: LANE_W]),
      .l_rd   (l_word[g*LANE_W +: LANE_W]),
      .r_rd   (r_word[g*LANE_W +: LANE_W])
    );
  end

  dls_port_ctrl u_left (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (l_cs_n),
    .cs        (l_cs),
    .rd_wr_n   (l_rd_wr_n),
    .lane_n    (l_lane_n),
    .oe_n      (l_oe_n),
    .pipe      (l_pipe),
    .bank_word (l_word),
    .wr_lanes  (l_wr),
    .rdata     (l_rdata),
    .lane_on   (l_lane_on)
  );

  dls_port_ctrl u_right (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (r_cs_n),
    .cs        (r_cs),
    .rd_wr_n   (r_rd_wr_n),
    .lane_n    (r_lane_n),
    .oe_n      (r_oe_n),
    .pipe      (r_pipe),
    .bank_word (r_word),
    .wr_lanes  (r_wr),
    .rdata     (r_rdata),
    .lane_on   (r_lane_on)
  );
endmodule

// File: rtl/dls_sram_chk.sv
module dls_sram_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       l_cs_n,
  input logic       l_cs,
  input logic       l_rd_wr_n,
  input logic [1:0] l_lane_n,
  input logic       l_oe_n,
  input logic       l_pipe,
  input logic [1:0] l_lane_on,
  input logic       r_cs_n,
  input logic       r_cs,
  input logic       r_oe_n,
  input logic       r_pipe,
  input logic [1:0] r_lane_on
);
  logic l_sel, r_sel, l_rd_lo;
  assign l_sel   = !l_cs_n && l_cs;
  assign r_sel   = !r_cs_n && r_cs;
  assign l_rd_lo = l_sel && l_rd_wr_n && !l_lane_n[0];

  assert_desel_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!l_pipe && !$past(l_sel)) |-> (l_lane_on == 2'b00));

  assert_lane_mask_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!l_pipe && $past(l_sel) && $past(l_lane_n[1])) |-> !l_lane_on[1]);

  assert_oe_gate_left_R8: assert property (@(posedge clk) disable iff (!rst_n)
    l_oe_n |-> (l_lane_on == 2'b00));

  assert_oe_gate_right_R8: assert property (@(posedge clk) disable iff (!rst_n)
    r_oe_n |-> (r_lane_on == 2'b00));

  assert_reenable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (r_pipe && !$past(r_sel, 3)) |-> (r_lane_on == 2'b00));

  assert_pipe_drive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (l_pipe && !l_oe_n && $past(rst_n) && $past(rst_n, 2) && $past(rst_n, 3)
     && $past(l_rd_lo, 2) && $past(l_sel, 3)) |-> l_lane_on[0]);
endmodule

bind dual_lane_sram dls_sram_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .l_cs_n    (l_cs_n),
  .l_cs      (l_cs),
  .l_rd_wr_n (l_rd_wr_n),
  .l_lane_n  (l_lane_n),
  .l_oe_n    (l_oe_n),
  .l_pipe    (l_pipe),
  .l_lane_on (l_lane_on),
  .r_cs_n    (r_cs_n),
  .r_cs      (r_cs),
  .r_oe_n    (r_oe_n),
  .r_pipe    (r_pipe),
  .r_lane_on (r_lane_on)
);

// File: tb/dual_lane_sram_bench.sv
`timescale 1ns/1ps
module dual_lane_sram_bench;
  localparam int AW = 10;
  // control nibble: {cs_n, cs, rd_wr_n, lane_n[1], lane_n[0]}
  localparam logic [4:0] IDLE    = 5'b10111;
  localparam logic [4:0] RD_BOTH = 5'b01100;
  localparam logic [4:0] RD_LO   = 5'b01110;
  localparam logic [4:0] WR_BOTH = 5'b01000;
  localparam logic [4:0] WR_LO   = 5'b01010;
  localparam logic [4:0] WR_HI   = 5'b01001;
  localparam logic [4:0] WR_NONE = 5'b01011;

  localparam logic [32:0] VEC [9] = '{
    {WR_BOTH,  10'd3,    18'h15A5A},
    {WR_BOTH,  10'd7,    18'h0F0F0},
    {WR_LO,    10'd3,    18'h3FFFF},
    {WR_HI,    10'd7,    18'h3FE00},
    {WR_NONE,  10'd3,    18'h00000},
    {5'b00000, 10'd7,    18'h00000},
    {WR_BOTH,  10'd1023, 18'h2468A},
    {WR_BOTH,  10'd0,    18'h13579},
    {5'b10000, 10'd0,    18'h00000}
  };
  localparam logic [AW-1:0] RB [4] = '{10'd3, 10'd7, 10'd1023, 10'd0};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic l_cs_n, l_cs, l_rw, r_cs_n, r_cs, r_rw;
  logic [1:0] l_lane_n, r_lane_n, l_lane_on, r_lane_on;
  logic [AW-1:0] l_addr, r_addr;
  logic [17:0] l_wdata, r_wdata, l_rdata, r_rdata;
  logic l_oe_n = 1'b0, r_oe_n = 1'b0, l_pipe = 1'b0, r_pipe = 1'b0;
  logic [17:0] sh [1 << AW];
  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  dual_lane_sram #(.ADDR_W(AW)) u_dual_lane_sram (
    .clk(clk), .rst_n(rst_n),
    .l_cs_n(l_cs_n), .l_cs(l_cs), .l_rd_wr_n(l_rw), .l_lane_n(l_lane_n),
    .l_addr(l_addr), .l_wdata(l_wdata), .l_oe_n(l_oe_n), .l_pipe(l_pipe),
    .l_rdata(l_rdata), .l_lane_on(l_lane_on),
    .r_cs_n(r_cs_n), .r_cs(r_cs), .r_rd_wr_n(r_rw), .r_lane_n(r_lane_n),
    .r_addr(r_addr), .r_wdata(r_wdata), .r_oe_n(r_oe_n), .r_pipe(r_pipe),
    .r_rdata(r_rdata), .r_lane_on(r_lane_on)
  );

  task automatic put_l(input logic [4:0] c, input logic [AW-1:0] a, input logic [17:0] d);
    {l_cs_n, l_cs, l_rw, l_lane_n} = c; l_addr = a; l_wdata = d;
  endtask

  task automatic put_r(input logic [4:0] c, input logic [AW-1:0] a, input logic [17:0] d);
    {r_cs_n, r_cs, r_rw, r_lane_n} = c; r_addr = a; r_wdata = d;
  endtask

  // shadow model of a write, per R1/R2/R3
  task automatic note(input logic [4:0] c, input logic [AW-1:0] a, input logic [17:0] d);
    if (!c[4] && c[3] && !c[2]) begin
      if (!c[0]) sh[a][8:0]  = d[8:0];
      if (!c[1]) sh[a][17:9] = d[17:9];
    end
  endtask

  function automatic logic [19:0] expw(input logic [1:0] on, input logic [17:0] w);
    return {on, on[1] ? w[17:9] : 9'h0, on[0] ? w[8:0] : 9'h0};
  endfunction

  task automatic chk(input string req, input logic [19:0] act, input logic [19:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(200000 * 8);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    put_l(IDLE, '0, '0);
    put_r(IDLE, '0, '0);
    repeat (3) @(negedge clk);
    chk("R11 reset left", {l_lane_on, l_rdata}, 20'h0);
    chk("R11 reset right", {r_lane_on, r_rdata}, 20'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // table walk: left-port writes with assorted lane/select patterns
    for (int i = 0; i < 9; i++) begin
      put_l(VEC[i][32:28], VEC[i][27:18], VEC[i][17:0]);
      note(VEC[i][32:28], VEC[i][27:18], VEC[i][17:0]);
      @(negedge clk);
    end
    put_l(IDLE, '0, '0);
    for (int j = 0; j < 4; j++) begin
      put_r(RD_BOTH, RB[j], '0);
      @(negedge clk);
      chk("R1 R2 R3 R4 readback", {r_lane_on, r_rdata}, expw(2'b11, sh[RB[j]]));
    end

    // lower lane only read
    put_r(RD_LO, 10'd3, '0);
    @(negedge clk);
    chk("R1 lower-lane read", {r_lane_on, r_rdata}, expw(2'b01, sh[3]));

    // deselected reads drive nothing
    put_r(5'b11100, 10'd3, '0);
    @(negedge clk);
    chk("R2 cs_n high", {r_lane_on, r_rdata}, 20'h0);
    put_r(5'b00100, 10'd3, '0);
    @(negedge clk);
    chk("R2 cs low", {r_lane_on, r_rdata}, 20'h0);

    // disable only after next edge
    put_r(RD_BOTH, 10'd0, '0);
    @(negedge clk);
    chk("R4 flow read", {r_lane_on, r_rdata}, expw(2'b11, sh[0]));
    put_r(RD_LO, 10'd0, '0);
    #1;
    chk("R6 still driven before edge", {r_lane_on, r_rdata}, expw(2'b11, sh[0]));
    @(negedge clk);
    chk("R6 upper off after edge", {r_lane_on, r_rdata}, expw(2'b01, sh[0]));

    // pipelined latency
    r_pipe = 1'b1;
    put_r(RD_BOTH, 10'd7, '0);
    @(negedge clk);
    chk("R5 previous result", {r_lane_on, r_rdata}, expw(2'b01, sh[0]));
    put_r(RD_BOTH, 10'd0, '0);
    @(negedge clk);
    chk("R5 one extra edge", {r_lane_on, r_rdata}, expw(2'b11, sh[7]));
    put_r(IDLE, '0, '0);
    @(negedge clk);
    chk("R5 second pipelined read", {r_lane_on, r_rdata}, expw(2'b11, sh[0]));

    // re-enable after deselect in pipelined mode
    put_r(RD_BOTH, 10'd3, '0);
    @(negedge clk);
    put_r(RD_BOTH, 10'd7, '0);
    @(negedge clk);
    chk("R7 first read suppressed", {r_lane_on, r_rdata}, 20'h0);
    @(negedge clk);
    chk("R7 second read driven", {r_lane_on, r_rdata}, expw(2'b11, sh[7]));

    // asynchronous output enable, no effect on storage
    r_oe_n = 1'b1;
    #1;
    chk("R8 oe off without clock", {r_lane_on, r_rdata}, 20'h0);
    r_pipe = 1'b0;
    put_r(WR_BOTH, 10'd20, 18'h0ABCD);
    note(WR_BOTH, 10'd20, 18'h0ABCD);
    @(negedge clk);
    put_r(RD_BOTH, 10'd20, '0);
    @(negedge clk);
    chk("R8 read while oe off", {r_lane_on, r_rdata}, 20'h0);
    r_oe_n = 1'b0;
    #1;
    chk("R8 oe on, write kept", {r_lane_on, r_rdata}, expw(2'b11, sh[20]));
    put_r(IDLE, '0, '0);
    @(negedge clk);

    // read-during-write across ports
    put_l(WR_BOTH, 10'd3, 18'h2C3C3);
    put_r(RD_BOTH, 10'd3, '0);
    @(negedge clk);
    chk("R9 old data same edge", {r_lane_on, r_rdata}, expw(2'b11, sh[3]));
    note(WR_BOTH, 10'd3, 18'h2C3C3);
    put_l(IDLE, '0, '0);
    @(negedge clk);
    chk("R9 new data next edge", {r_lane_on, r_rdata}, expw(2'b11, sh[3]));

    // write-write collision: left wins
    put_l(WR_BOTH, 10'd5, 18'h11111);
    put_r(WR_BOTH, 10'd5, 18'h22222);
    note(WR_BOTH, 10'd5, 18'h22222);
    note(WR_BOTH, 10'd5, 18'h11111);
    @(negedge clk);
    put_r(IDLE, '0, '0);
    put_l(RD_BOTH, 10'd5, '0);
    @(negedge clk);
    chk("R10 left wins", {l_lane_on, l_rdata}, expw(2'b11, 18'h11111));
    put_l(WR_LO, 10'd6, 18'h00155);
    put_r(WR_BOTH, 10'd6, 18'h2AAAA);
    note(WR_BOTH, 10'd6, 18'h2AAAA);
    note(WR_LO, 10'd6, 18'h00155);
    @(negedge clk);
    put_l(IDLE, '0, '0);
    put_r(RD_BOTH, 10'd6, '0);
    @(negedge clk);
    chk("R10 per-lane clash", {r_lane_on, r_rdata}, expw(2'b11, {9'h155, 9'h155}));

    // reset mid-run keeps array
    put_r(IDLE, '0, '0);
    rst_n = 1'b0;
    #1;
    chk("R11 reset clears right", {r_lane_on, r_rdata}, 20'h0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    put_r(RD_BOTH, 10'd7, '0);
    @(negedge clk);
    chk("R11 array kept", {r_lane_on, r_rdata}, expw(2'b11, sh[7]));
    put_r(IDLE, '0, '0);
    @(negedge clk);

    finish_run();
  end
endmodule